// File: doc/BRIEF.md
# Latched Channel Selector with Break-Before-Make

This block controls a bank of sixteen analog switches that share one common node. It turns a binary channel address and an enable bit into one-hot switch-enable lines, and at most one line is high at any time. The address and enable pass through storage that is gated by an active-low write strobe. While the strobe is low the storage is transparent, so the switches follow the live inputs. On the strobe's rising edge the storage captures the inputs, and after that later input changes are ignored. An active-low clear empties the storage, which opens every switch.

The block is fully synchronous to a system clock. The strobe, the clear and the data inputs are passed through a synchroniser of matched depth. Because all four take the same path, the capture still uses the data that was present during the strobe's last low cycle. A sequencer stands between the stored selection and the switch lines. When the selection moves from one closed channel to another, it opens the old switch first and then holds every line low for a programmable number of cycles before it closes the new one. Opening a switch has no delay.

Top module: `chan_sel_latch`

## Requirements
- R1: After system reset every switch-enable output is low.
- R2: With the enable stored as 1, stored address k (binary, 0 to 15) drives output bit k high and every other bit low. Address 0 maps to bit 0 and address 15 maps to bit 15.
- R3: With the enable stored as 0, every output is low whatever the stored address.
- R4: While the write strobe is low and the clear is inactive, the outputs follow changes on the address and enable inputs.
- R5: While the write strobe is high and the clear is inactive, changes on the address and enable inputs have no effect on the outputs.
- R6: The selection in force after the strobe's rising edge is the address and enable present in the last clock cycle the strobe was low. Values that arrive together with the rising edge are not captured.
- R7: A low clear forces every output low and empties the storage. It wins over a low write strobe.
- R8: After the clear is released with the strobe high, the outputs stay low until a new write occurs.
- R9: In every cycle at most one output is high.
- R10: When the closed channel changes to a different channel, all outputs are low for at least GAP_CYC cycles (default 2) between the old bit falling and the new bit rising.
- R11: Writing the channel that is already closed leaves its output high with no low cycle.
- R12: Turning a switch off adds no gap. Turn-off takes effect SYNC_STAGES+2 clock edges after an input change sampled on the first edge (4 edges by default), and the switch is still on after the edge before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| addr_i | input | ADDR_W | Binary channel address |
| en_i | input | 1 | Channel enable, 1 = close the addressed switch |
| wr_n_i | input | 1 | Write strobe, active low (transparent while low) |
| clr_n_i | input | 1 | Storage clear, active low |
| sw_on_o | output | 2**ADDR_W | One-hot switch enables, bit k = channel k |

## Verification
Every address value is written in turn with a strobe pulse. This shows that each bit decodes by itself, and that each step between different channels passes through the all-off gap, which a cycle monitor measures. The strobe is then held low while the address changes, to tell transparency apart from edge capture. The address is also changed in the same cycle as the strobe's rising edge, to tell apart which value is taken. Further cases change the inputs with the strobe high, clear with the strobe low, and rewrite the channel already selected; these separate hold, priority and the no-gap path. Turn-off latency is checked at the exact edge.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

   // Sequencer states for break-before-make control
   typedef enum logic [1:0] {
      BBM_IDLE = 2'd0,   // all switches open, free to close one
      BBM_ON   = 2'd1,   // one switch closed
      BBM_GAP  = 2'd2    // dead interval after an opening
   } bbm_state_e;

   localparam int unsigned DEF_ADDR_W      = 4;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   localparam int unsigned DEF_GAP_CYC     = 2;

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   initial begin
      assert (STAGES >= 1) else $error("chsel_sync: STAGES must be at least 1");
      assert (W >= 1) else $error("chsel_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[0] <= RST_VAL;
            else        pipe_q[0] <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
            end else begin
               pipe_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/chsel_hold.sv
module chsel_hold #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_s_n,
   input  logic              wr_s_n,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic              en_s,
   output logic [ADDR_W-1:0] hold_addr_o,
   output logic              hold_en_o
);

   // Clear first, then transparent-while-low; strobe high retains.
   // The final low cycle is what remains when the strobe rises.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_addr_o <= '0;
         hold_en_o   <= 1'b0;
      end else if (!clr_s_n) begin
         hold_addr_o <= '0;
         hold_en_o   <= 1'b0;
      end else if (!wr_s_n) begin
         hold_addr_o <= addr_s;
         hold_en_o   <= en_s;
      end
   end

   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s_n |=> (!hold_en_o && hold_addr_o == '0));

   a_r5_strobe_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s_n && wr_s_n) |=> ($stable(hold_addr_o) && $stable(hold_en_o)));

   a_r4_transparent_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s_n && !wr_s_n) |=> (hold_addr_o == $past(addr_s) && hold_en_o == $past(en_s)));

endmodule

// File: rtl/chsel_bbm.sv
module chsel_bbm
   import chsel_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned GAP_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_valid_i,
   input  logic [ADDR_W-1:0] tgt_idx_i,
   output logic              cur_valid_o,
   output logic [ADDR_W-1:0] cur_idx_o
);

   localparam int unsigned CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
   localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

   initial begin
      assert (GAP_CYC >= 1) else $error("chsel_bbm: GAP_CYC must be at least 1");
   end

   bbm_state_e           state_q;
   logic [CNT_W-1:0]     gap_q;
   logic [ADDR_W-1:0]    idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BBM_IDLE;
         gap_q   <= '0;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            BBM_IDLE: begin
               if (tgt_valid_i) begin
                  state_q <= BBM_ON;
                  idx_q   <= tgt_idx_i;
               end
            end
            BBM_ON: begin
               // open at once on disable or on a different channel
               if (!tgt_valid_i || tgt_idx_i != idx_q) begin
                  state_q <= BBM_GAP;
                  gap_q   <= GAP_LOAD;
               end
            end
            BBM_GAP: begin
               if (gap_q == '0) begin
                  if (tgt_valid_i) begin
                     state_q <= BBM_ON;
                     idx_q   <= tgt_idx_i;
                  end else begin
                     state_q <= BBM_IDLE;
                  end
               end else begin
                  gap_q <= gap_q - 1'b1;
               end
            end
            default: state_q <= BBM_IDLE;
         endcase
      end
   end

   assign cur_valid_o = (state_q == BBM_ON);
   assign cur_idx_o   = idx_q;

   // R3 / R12: a missing target opens the switch on the next edge
   a_r3_disabled_opens: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_valid_i |=> !cur_valid_o);

   a_r11_same_channel_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid_o && tgt_valid_i && tgt_idx_i == cur_idx_o) |=> (cur_valid_o && $stable(cur_idx_o)));

   a_r10_close_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid_o && tgt_valid_i && tgt_idx_i != cur_idx_o) |=> !cur_valid_o);

endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned NCH   = 1 << ADDR_W
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] idx_i,
   output logic [NCH-1:0]    onehot_o
);

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_line
         assign onehot_o[k] = valid_i && (idx_i == ADDR_W'(k));
      end
   endgenerate

endmodule

// File: rtl/chan_sel_latch.sv
module chan_sel_latch
   import chsel_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int unsigned GAP_CYC     = DEF_GAP_CYC,
   localparam int unsigned NCH        = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              en_i,
   input  logic              wr_n_i,
   input  logic              clr_n_i,
   output logic [NCH-1:0]    sw_on_o
);

   localparam int unsigned RUN_W = $clog2(GAP_CYC + 2);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 8) else $error("chan_sel_latch: ADDR_W out of range");
      assert (SYNC_STAGES >= 1) else $error("chan_sel_latch: SYNC_STAGES must be at least 1");
      assert (GAP_CYC >= 1) else $error("chan_sel_latch: GAP_CYC must be at least 1");
   end

   logic [1:0]        ctl_s;        // {clr_n, wr_n} synchronised
   logic [ADDR_W:0]   dat_s;        // {en, addr} synchronised
   logic [ADDR_W-1:0] hold_addr;
   logic              hold_en;
   logic              cur_valid;
   logic [ADDR_W-1:0] cur_idx;

   // strobes and data share one delay so capture stays aligned
   chsel_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({clr_n_i, wr_n_i}),
      .q_o   (ctl_s)
   );

   chsel_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_dat (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({en_i, addr_i}),
      .q_o   (dat_s)
   );

   chsel_hold #(.ADDR_W(ADDR_W)) i_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_s_n     (ctl_s[1]),
      .wr_s_n      (ctl_s[0]),
      .addr_s      (dat_s[ADDR_W-1:0]),
      .en_s        (dat_s[ADDR_W]),
      .hold_addr_o (hold_addr),
      .hold_en_o   (hold_en)
   );

   chsel_bbm #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) i_bbm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tgt_valid_i (hold_en),
      .tgt_idx_i   (hold_addr),
      .cur_valid_o (cur_valid),
      .cur_idx_o   (cur_idx)
   );

   chsel_decode #(.ADDR_W(ADDR_W)) i_decode (
      .valid_i  (cur_valid),
      .idx_i    (cur_idx),
      .onehot_o (sw_on_o)
   );

   // ---- checker support: all-off run length and last closed channel ----
   logic [RUN_W-1:0]  off_run_q;
   logic [NCH-1:0]    last_on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_run_q <= '0;
         last_on_q <= '0;
      end else if (sw_on_o == '0) begin
         if (off_run_q != RUN_W'(GAP_CYC + 1)) off_run_q <= off_run_q + 1'b1;
      end else begin
         off_run_q <= '0;
         last_on_q <= sw_on_o;
      end
   end

   a_r10_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_on_o != '0 && last_on_q != '0 && sw_on_o != last_on_q) |-> (off_run_q >= RUN_W'(GAP_CYC)));

   a_r9_single_closed: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_on_o));

   a_r8_stay_open_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_en && ctl_s[0]) |=> !hold_en);

endmodule

// File: tb/test_chan_sel_latch.sv
module test_chan_sel_latch;

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned GAP    = 2;
   localparam int unsigned NCH    = 1 << ADDR_W;
   localparam int unsigned SETTLE = SYNC + GAP + 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              en = 1'b0;
   logic              wr_n = 1'b1;
   logic              clr_n = 1'b1;
   logic [NCH-1:0]    sw_on;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   chan_sel_latch #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC), .GAP_CYC(GAP)) i_chan_sel_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr),
      .en_i    (en),
      .wr_n_i  (wr_n),
      .clr_n_i (clr_n),
      .sw_on_o (sw_on)
   );

   function automatic logic [NCH-1:0] bit_of(input int k);
      logic [NCH-1:0] v = '0;
      v[k] = 1'b1;
      return v;
   endfunction

   task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // ---- cycle monitor: R9 one-hot, R10 gap length, R11 drop flag ----
   int             mon_multi  = 0;
   int             off_run    = 0;
   logic [NCH-1:0] last_on    = '0;
   bit             zero_seen  = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ($countones(sw_on) > 1) mon_multi++;
         if (sw_on == '0) begin
            off_run++;
            zero_seen = 1'b1;
         end else begin
            if (last_on != '0 && sw_on != last_on) begin
               checks++;
               if (off_run < GAP) begin
                  fails++;
                  $display("FAIL R10: actual %0d off cycles expected >= %0d", off_run, GAP);
               end
            end
            off_run = 0;
            last_on = sw_on;
         end
      end
   end

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic write_ch(input int a, input logic e);
      @(negedge clk);
      addr = ADDR_W'(a); en = e; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      settle();
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      check("R1 reset outputs low", sw_on, '0);
      rst_n = 1'b1;
      settle();
      check("R1 outputs low after reset release", sw_on, '0);
   endtask

   task automatic t_decode_all();
      for (int k = 0; k < NCH; k++) begin
         write_ch(k, 1'b1);
         check($sformatf("R2 address %0d", k), sw_on, bit_of(k));
      end
   endtask

   task automatic t_disable();
      write_ch(9, 1'b1);
      write_ch(12, 1'b0);
      check("R3 enable 0 all off", sw_on, '0);
   endtask

   task automatic t_transparent();
      @(negedge clk);
      clr_n = 1'b1; addr = 4'd2; en = 1'b1; wr_n = 1'b0;
      settle();
      check("R4 transparent first address", sw_on, bit_of(2));
      addr = 4'd7;
      settle();
      check("R4 transparent follows change", sw_on, bit_of(7));
      en = 1'b0;
      settle();
      check("R4 transparent follows enable", sw_on, '0);
      en = 1'b1;
      settle();
      wr_n = 1'b1;
      settle();
   endtask

   task automatic t_hold();
      write_ch(3, 1'b1);
      addr = 4'd9; en = 1'b1;
      settle();
      check("R5 address change ignored", sw_on, bit_of(3));
      en = 1'b0;
      settle();
      check("R5 enable change ignored", sw_on, bit_of(3));
   endtask

   task automatic t_capture();
      @(negedge clk);
      addr = 4'd11; en = 1'b1; wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1; addr = 4'd13;
      settle();
      check("R6 last low-cycle value captured", sw_on, bit_of(11));
   endtask

   task automatic t_clear();
      write_ch(5, 1'b1);
      @(negedge clk);
      clr_n = 1'b0;
      settle();
      check("R7 clear opens all", sw_on, '0);
      addr = 4'd6; en = 1'b1; wr_n = 1'b0;
      settle();
      check("R7 clear wins over strobe", sw_on, '0);
      wr_n = 1'b1;
      settle();
      clr_n = 1'b1;
      settle();
      check("R8 off after clear release", sw_on, '0);
      addr = 4'd0;
      settle();
      check("R8 input change without write stays off", sw_on, '0);
      write_ch(6, 1'b1);
      check("R8 new write closes", sw_on, bit_of(6));
   endtask

   task automatic t_same_channel();
      write_ch(8, 1'b1);
      zero_seen = 1'b0;
      write_ch(8, 1'b1);
      check("R11 same channel still on", sw_on, bit_of(8));
      checks++;
      if (zero_seen) begin
         fails++;
         $display("FAIL R11: actual low cycle seen expected none");
      end
   endtask

   task automatic t_turnoff_latency();
      write_ch(1, 1'b1);
      @(negedge clk);
      en = 1'b0; wr_n = 1'b0;
      repeat (SYNC + 1) @(posedge clk);
      #1;
      check("R12 still on one edge early", sw_on, bit_of(1));
      @(posedge clk);
      #1;
      check("R12 off at exact edge", sw_on, '0);
      @(negedge clk);
      wr_n = 1'b1;
      settle();
   endtask

   initial begin
      t_reset();
      t_decode_all();
      t_disable();
      t_transparent();
      t_hold();
      t_capture();
      t_clear();
      t_same_channel();
      t_turnoff_latency();
      checks++;
      if (mon_multi != 0) begin
         fails++;
         $display("FAIL R9: actual %0d multi-on cycles expected 0", mon_multi);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule